// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out store of 64 words, each 36 bits wide, between two clock domains. A producer on the write clock pushes words in. A consumer on the read clock pops them out in the same order. The two clocks run freely and may be unrelated in phase and frequency. They may also be one clock, so a push and a pop can land on the same edge.

Each side sees only flags that are built in its own clock domain. The write side gets `full` and `afull`. The read side gets `empty` and `aempty`. The pointers cross between the domains as gray code through a chain of synchronizer flops. A synchronized pointer therefore lags the true pointer, and the flags are pessimistic: they can assert at once but clear late, never early. Read data comes from a register, so it is valid one read-clock cycle after a pop is accepted.

Each clock domain runs its own phase machine with three states:
- `PH_INIT` is held for as long as `rst_n` is low. In this state the domain's offset register is set to the default value of 8.
- `PH_CFG` is entered on the first domain clock after reset is released. In this state the domain's offset register is loaded from its input bus on every cycle in which `ofs_load` is high.
- `PH_RUN` is entered once the domain's synchronized reset has released. In this state the offset is frozen and pushes or pops are accepted.

The transitions are:
- INIT→CFG, unconditionally on the first clock after release.
- CFG→RUN, when the synchronized reset is high.
- Any state→INIT, whenever `rst_n` goes low.

Top module: `xclk_flag_fifo`

## Requirements
- R1: After reset, `empty`=1, `aempty`=1, `full`=0 and `afull`=0.
- R2: Words leave the read port in the order they were accepted at the write port, with all 36 bits unchanged, including while pushes and pops run together on both clocks.
- R3: A push while `full` is high is dropped: no stored word is overwritten and the dropped word never appears at the read port.
- R4: A pop while `empty` is high is dropped: `rd_data` keeps its value and the read pointer does not move, so the next word written is the next word read.
- R5: `full` is high when 64 words are held. After a pop, `full` clears within a few write-clock cycles.
- R6: `afull` is high when the occupancy seen by the write side is at least 64 minus the almost-full offset.
- R7: `aempty` is high when the occupancy seen by the read side is at most the almost-empty offset.
- R8: Each offset is taken from its bus (`af_ofs` or `ae_ofs`) when `ofs_load` is held high through reset and for three clocks of that domain after release. Otherwise the offset is 8. Values on the offset buses and `ofs_load` during normal operation have no effect.
- R9: `rd_data` holds the popped word from the first read-clock edge after the edge that accepted the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ofs_load | input | 1 | Take offsets from the buses during the configuration phase |
| af_ofs | input | 6 | Almost-full offset, in free words |
| ae_ofs | input | 6 | Almost-empty offset, in stored words |
| wr_en | input | 1 | Push request, sampled on wclk |
| wr_data | input | 36 | Word to push |
| full | output | 1 | 64 words held (write domain) |
| afull | output | 1 | Occupancy at or above the almost-full level (write domain) |
| rd_en | input | 1 | Pop request, sampled on rclk |
| rd_data | output | 36 | Registered word from the last accepted pop |
| empty | output | 1 | No word held (read domain) |
| aempty | output | 1 | Occupancy at or below the almost-empty level (read domain) |

## Verification
The hardest situation to reach from the ports is a continuous push and pop on two unrelated clocks. In that case the flags move on both sides while the gray pointers are in flight, and edges sometimes coincide. The bench drives write and read clocks with co-prime periods and runs a producer and a consumer in parallel. Each one issues a request only when its own flag allows, for 200 words. This makes the pointers cross the domains at every phase offset. The full-boundary cases use a long fill with a dropped extra push, followed by a drain ending in a dropped extra pop, so that both ignored-request paths are observed through the data that comes out afterwards.

// File: rtl/xff_pkg.sv
package xff_pkg;
    typedef enum logic [1:0] {
        PH_INIT = 2'd0,
        PH_CFG  = 2'd1,
        PH_RUN  = 2'd2
    } phase_t;
endpackage

// File: rtl/xff_sync.sv
module xff_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xff_phase.sv
module xff_phase
    import xff_pkg::*;
#(
    parameter int OW      = 6,
    parameter int DEF_OFS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ofs_load,
    input  logic [OW-1:0] ofs_in,
    output logic          run,
    output logic [OW-1:0] ofs
);
    localparam logic [OW-1:0] DEF = OW'(DEF_OFS);

    logic [1:0]    rsync;
    phase_t        st, st_nx;
    logic [OW-1:0] ofs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync <= 2'b00;
        else        rsync <= {rsync[0], 1'b1};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PH_INIT;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            PH_INIT: st_nx = PH_CFG;
            PH_CFG:  st_nx = rsync[1] ? PH_RUN : PH_CFG;
            PH_RUN:  st_nx = PH_RUN;
            default: st_nx = PH_INIT;
        endcase
    end

    // outputs: offset register follows the phase
    always_ff @(posedge clk) begin
        unique case (st)
            PH_INIT: ofs_q <= DEF;
            PH_CFG:  if (ofs_load) ofs_q <= ofs_in;
            PH_RUN:  ofs_q <= ofs_q;
            default: ofs_q <= DEF;
        endcase
    end

    assign run = (st == PH_RUN);
    assign ofs = ofs_q;

    // R8: once running, the offset never changes
    a_r8_ofs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_RUN) |=> $stable(ofs_q));
endmodule

// File: rtl/xff_wr_ctrl.sv
module xff_wr_ctrl #(
    parameter int AW      = 6,
    parameter int DEF_OFS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ofs_load,
    input  logic [AW-1:0] ofs_in,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic          full,
    output logic          afull
);
    localparam int          PW    = AW + 1;
    localparam logic [AW:0] DEPTH = PW'(1 << AW);

    logic          run;
    logic [AW-1:0] ofs;
    logic [AW:0]   wbin, wbin_nx, rbin_s, cnt;

    xff_phase #(.OW(AW), .DEF_OFS(DEF_OFS)) u_phase (
        .clk(clk), .rst_n(rst_n), .ofs_load(ofs_load), .ofs_in(ofs_in),
        .run(run), .ofs(ofs)
    );

    always_comb begin
        for (int i = 0; i <= AW; i++) rbin_s[i] = ^(rgray_s >> i);
    end

    assign cnt     = wbin - rbin_s;
    assign full    = cnt[AW];
    assign afull   = cnt >= (DEPTH - {1'b0, ofs});
    assign we      = wr_en & run & ~full;
    assign wbin_nx = wbin + PW'(we);
    assign waddr   = wbin[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en) |=> $stable(wbin));
    a_r5_full_has_afull: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> afull);
    a_r2_wgray_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wgray ^ $past(wgray)));
endmodule

// File: rtl/xff_rd_ctrl.sv
module xff_rd_ctrl #(
    parameter int AW      = 6,
    parameter int DEF_OFS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ofs_load,
    input  logic [AW-1:0] ofs_in,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_s,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] raddr,
    output logic          re,
    output logic          empty,
    output logic          aempty
);
    localparam int PW = AW + 1;

    logic          run;
    logic [AW-1:0] ofs;
    logic [AW:0]   rbin, rbin_nx, wbin_s, cnt;

    xff_phase #(.OW(AW), .DEF_OFS(DEF_OFS)) u_phase (
        .clk(clk), .rst_n(rst_n), .ofs_load(ofs_load), .ofs_in(ofs_in),
        .run(run), .ofs(ofs)
    );

    always_comb begin
        for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    assign cnt     = wbin_s - rbin;
    assign empty   = (cnt == '0);
    assign aempty  = cnt <= {1'b0, ofs};
    assign re      = rd_en & run & ~empty;
    assign rbin_nx = rbin + PW'(re);
    assign raddr   = rbin[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> $stable(rbin));
    a_r7_empty_has_aempty: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> aempty);
    a_r2_rgray_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rgray ^ $past(rgray)));
endmodule

// File: rtl/xff_ram.sv
module xff_ram #(
    parameter int AW = 6,
    parameter int DW = 36
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/xclk_flag_fifo.sv
module xclk_flag_fifo #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2,
    parameter int DEF_OFS     = 8
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              ofs_load,
    input  logic [ADDR_W-1:0] af_ofs,
    input  logic [ADDR_W-1:0] ae_ofs,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              afull,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              aempty
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              we, re;

    xff_wr_ctrl #(.AW(ADDR_W), .DEF_OFS(DEF_OFS)) u_wr (
        .clk(wclk), .rst_n(rst_n), .ofs_load(ofs_load), .ofs_in(af_ofs),
        .wr_en(wr_en), .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr),
        .we(we), .full(full), .afull(afull)
    );

    xff_rd_ctrl #(.AW(ADDR_W), .DEF_OFS(DEF_OFS)) u_rd (
        .clk(rclk), .rst_n(rst_n), .ofs_load(ofs_load), .ofs_in(ae_ofs),
        .rd_en(rd_en), .wgray_s(wgray_s), .rgray(rgray), .raddr(raddr),
        .re(re), .empty(empty), .aempty(aempty)
    );

    xff_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    xff_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    xff_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
        .rclk(rclk), .re(re), .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: tb/xclk_flag_fifo_bench.sv
`timescale 1ns/1ps
module xclk_flag_fifo_bench;
    logic        wclk = 1'b0, rclk = 1'b0;
    logic        rst_n = 1'b0, ofs_load = 1'b0;
    logic [5:0]  af_ofs = '0, ae_ofs = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic        full, afull, empty, aempty;
    logic [35:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #4   wclk = ~wclk;   // 125 MHz
    always #5.5 rclk = ~rclk;   // unrelated read clock

    xclk_flag_fifo u_xclk_flag_fifo (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .ofs_load(ofs_load),
        .af_ofs(af_ofs), .ae_ofs(ae_ofs), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .afull(afull), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .aempty(aempty)
    );

    function automatic logic [35:0] pat(int i);
        return {4'(i % 16), 32'(i) * 32'h0101_0101 ^ 32'hA5C3_0000};
    endfunction

    task automatic check(string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic load, logic [5:0] af, logic [5:0] ae);
        rst_n = 1'b0; ofs_load = load; af_ofs = af; ae_ofs = ae;
        wr_en = 1'b0; rd_en = 1'b0;
        repeat (4) @(negedge rclk);
        rst_n = 1'b1;
        repeat (6) @(negedge rclk);
        ofs_load = 1'b0;
        repeat (4) @(negedge wclk);
    endtask

    task automatic push(logic [35:0] d);   // call at negedge wclk
        wr_en = 1'b1; wr_data = d;
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic pop(output logic [35:0] d);   // call at negedge rclk
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (5) @(negedge rclk);
        repeat (5) @(negedge wclk);
    endtask

    // Default offsets, threshold edges, in-run load ignored
    task automatic test_default();
        logic [35:0] d;
        do_reset(1'b0, 6'd20, 6'd30);
        check("R1 empty", 36'(empty), 36'd1);
        check("R1 aempty", 36'(aempty), 36'd1);
        check("R1 full", 36'(full), 36'd0);
        check("R1 afull", 36'(afull), 36'd0);
        ofs_load = 1'b1; af_ofs = 6'd20; ae_ofs = 6'd30;   // R8: no effect while running
        @(negedge wclk);
        for (int i = 0; i < 55; i++) push(pat(i));
        check("R6/R8 afull at 55 words, default offset", 36'(afull), 36'd0);
        push(pat(55));
        check("R6 afull at 56 words", 36'(afull), 36'd1);
        check("R5 not full at 56", 36'(full), 36'd0);
        ofs_load = 1'b0;
        settle();
        @(negedge rclk);
        check("R7 aempty at 56", 36'(aempty), 36'd0);
        for (int i = 0; i < 47; i++) begin
            pop(d);
            check("R2/R9 data order", d, pat(i));
        end
        check("R7/R8 aempty at 9 words", 36'(aempty), 36'd0);
        pop(d);
        check("R2 data", d, pat(47));
        check("R7 aempty at 8 words", 36'(aempty), 36'd1);
        for (int i = 48; i < 56; i++) begin
            pop(d);
            check("R2 data tail", d, pat(i));
        end
        check("R2 empty after drain", 36'(empty), 36'd1);
    endtask

    // Loaded offsets, full, dropped push and dropped pop
    task automatic test_full();
        logic [35:0] d, last;
        do_reset(1'b1, 6'd2, 6'd3);
        @(negedge wclk);
        for (int i = 0; i < 61; i++) push(pat(100 + i));
        check("R8 afull at 61, loaded offset 2", 36'(afull), 36'd0);
        push(pat(161));
        check("R6/R8 afull at 62", 36'(afull), 36'd1);
        push(pat(162));
        check("R5 not full at 63", 36'(full), 36'd0);
        push(pat(163));
        check("R5 full at 64", 36'(full), 36'd1);
        push(36'hF_DEAD_BEEF);   // R3: dropped
        check("R3 still full", 36'(full), 36'd1);
        settle();
        @(negedge rclk);
        pop(d);
        check("R3 first word kept", d, pat(100));
        repeat (5) @(negedge wclk);
        check("R5 full clears after pop", 36'(full), 36'd0);
        @(negedge rclk);
        for (int k = 2; k <= 64; k++) begin
            pop(d);
            check("R2/R3 data", d, pat(99 + k));
            if (k == 60) check("R7 aempty at 4, offset 3", 36'(aempty), 36'd0);
            if (k == 61) check("R7 aempty at 3", 36'(aempty), 36'd1);
        end
        last = d;
        check("R3 empty, dropped word absent", 36'(empty), 36'd1);
        pop(d);   // R4: dropped
        check("R4 rd_data unchanged", d, last);
        @(negedge wclk);
        push(pat(500));
        settle();
        @(negedge rclk);
        pop(d);
        check("R4 next word after dropped pop", d, pat(500));
    endtask

    // Concurrent push and pop on both clocks
    task automatic test_stream();
        int bad = 0, got = 0;
        do_reset(1'b0, 6'd0, 6'd0);
        fork
            begin : writer
                int n = 0;
                while (n < 200) begin
                    @(negedge wclk);
                    wr_en = !full;
                    if (!full) begin wr_data = pat(1000 + n); n++; end
                end
                @(negedge wclk);
                wr_en = 1'b0;
            end
            begin : reader
                logic pend = 1'b0;
                int guard = 0;
                while (got < 200 && guard < 5000) begin
                    @(negedge rclk);
                    guard++;
                    if (pend) begin
                        if (rd_data !== pat(1000 + got)) begin
                            bad++;
                            $display("FAIL R2 stream word %0d actual=%h expected=%h",
                                     got, rd_data, pat(1000 + got));
                        end
                        got++;
                    end
                    pend = !empty && (got + 1 < 200 || !pend) && got < 200;
                    rd_en = pend;
                end
                rd_en = 1'b0;
            end
        join
        check("R2/R9 stream mismatches", 36'(bad), 36'd0);
        check("R2 stream word count", 36'(got), 36'd200);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_default();
        test_full();
        test_stream();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule